// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

A multi-cycle sequencer and datapath for a one-accumulator machine. Every instruction is carried out as a chain of register transfers through a program counter, an instruction register, a memory address register and a memory buffer register. These transfers are grouped into fetch, indirect, execute and interrupt subcycles. The block drives a synchronous single-port memory. Read data arrives one cycle after the read request, and the sequencer always waits out that latency before it captures the word.

Instruction words are 16 bits wide: opcode in bits 15:13, indirect flag in bit 12, address field in bits 11:0. The machine can load the accumulator, add memory to it, store it, and set its interrupt enable. With indirect addressing the address field points at a memory word, and the low 12 bits of that word are the real operand address. A single maskable interrupt line is examined when an execute subcycle finishes. On entry the return PC is written through the buffer register to a save location, and execution resumes at a handler address.

Top module: `acc_cpu_seq`

## Requirements
- R1: While reset is asserted, pc_o, acc_o and status_o are zero, and neither mem_rd_o nor mem_wr_o is active.
- R2: Each fetch reads memory at the current PC and raises the PC by one. Opcode 0 is load, 1 is add, 2 is store and 4 is interrupt-enable.
- R3: A load copies the memory word at the operand address into the accumulator.
- R4: An add puts accumulator plus operand into the accumulator and updates status_o, with bit 0 zero, bit 1 sign, bit 2 carry out and bit 3 signed overflow. No other instruction changes bits 3:0.
- R5: A store writes the accumulator to the operand address.
- R6: When bit 12 is set on a load, add or store, the low 12 bits of the word at the address field are used as the operand address.
- R7: Read data is captured in the cycle after the read request. A read and a write are never requested together, and two reads never come in back-to-back cycles.
- R8: Opcode 4 sets the interrupt enable (status_o bit 4). While that bit is clear, irq_i has no effect.
- R9: If irq_i is high and interrupts are enabled when an execute subcycle ends, the next PC is written to SAVE_ADDR, fetching resumes at HANDLER_ADDR, and interrupt enable is cleared.
- R10: Opcodes 3, 5, 6 and 7 change nothing except the PC, and they write no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Maskable interrupt request |
| mem_addr_o | output | 12 | Memory address (memory address register) |
| mem_wdata_o | output | 16 | Write data (memory buffer register) |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| status_o | output | 5 | {ie, overflow, carry, sign, zero} |

## Verification
The memory write of a store and the acceptance of an interrupt happen in the same cycle: the final cycle of the store execute subcycle. The bench raises irq_i in exactly that cycle, when it sees the store write going out. It then expects the store data at its own address, followed by a save write whose value is the address of the next instruction, and the first handler write with interrupts disabled. The request is left high for the rest of the run, so a second entry would appear as an unexpected write. Earlier in the run, the request is held high while interrupts are disabled to show that it is masked.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_LDA = 3'd0;
  localparam logic [OP_W-1:0] OP_ADD = 3'd1;
  localparam logic [OP_W-1:0] OP_STA = 3'd2;
  localparam logic [OP_W-1:0] OP_ION = 3'd4;

  typedef enum logic [3:0] {
    ST_FETCH_A, ST_FETCH_R, ST_FETCH_C, ST_DECODE,
    ST_IND_R, ST_IND_C, ST_IND_M,
    ST_EXEC_R, ST_EXEC_C, ST_EXEC_ALU,
    ST_STORE_M, ST_STORE_W,
    ST_INT_M, ST_INT_W
  } seq_state_e;

  localparam int STAT_Z  = 0;
  localparam int STAT_S  = 1;
  localparam int STAT_C  = 2;
  localparam int STAT_V  = 3;
  localparam int STAT_IE = 4;
  localparam int STAT_W  = 5;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         sign_o,
  output logic         zero_o
);
  always_comb begin
    {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
    sign_o = sum_o[W-1];
    zero_o = (sum_o == '0);
  end
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            ind_i,
  input  logic            irq_take_i,
  output seq_state_e      state_o
);
  seq_state_e state_q, state_d;
  logic       mem_op, is_store;

  assign mem_op   = (op_i == OP_LDA) || (op_i == OP_ADD) || (op_i == OP_STA);
  assign is_store = (op_i == OP_STA);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH_A:  state_d = ST_FETCH_R;
      ST_FETCH_R:  state_d = ST_FETCH_C;
      ST_FETCH_C:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (mem_op) begin
          if (ind_i)         state_d = ST_IND_R;
          else if (is_store) state_d = ST_STORE_M;
          else               state_d = ST_EXEC_R;
        end else begin
          // trivial execute ends here
          state_d = irq_take_i ? ST_INT_M : ST_FETCH_A;
        end
      end
      ST_IND_R:    state_d = ST_IND_C;
      ST_IND_C:    state_d = ST_IND_M;
      ST_IND_M:    state_d = is_store ? ST_STORE_M : ST_EXEC_R;
      ST_EXEC_R:   state_d = ST_EXEC_C;
      ST_EXEC_C:   state_d = ST_EXEC_ALU;
      ST_EXEC_ALU: state_d = irq_take_i ? ST_INT_M : ST_FETCH_A;
      ST_STORE_M:  state_d = ST_STORE_W;
      ST_STORE_W:  state_d = irq_take_i ? ST_INT_M : ST_FETCH_A;
      ST_INT_M:    state_d = ST_INT_W;
      ST_INT_W:    state_d = ST_FETCH_A;
      default:     state_d = ST_FETCH_A;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_A;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 16,
  parameter logic [11:0] HANDLER_ADDR = 12'h100,
  parameter logic [11:0] SAVE_ADDR    = 12'h0FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int OP_LSB  = DATA_W - OP_W;
  localparam int IND_BIT = OP_LSB - 1;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, acc_q;
  logic [3:0]        flags_q;
  logic              ie_q;
  seq_state_e        state;

  logic [DATA_W-1:0] dec_word;
  logic [OP_W-1:0]   op;
  logic              ind, irq_take;
  logic [DATA_W-1:0] sum;
  logic              c_add, v_add, s_add, z_add;

  // in decode the word is still in the buffer register
  assign dec_word = (state == ST_DECODE) ? mbr_q : ir_q;
  assign op       = dec_word[DATA_W-1:OP_LSB];
  assign ind      = dec_word[IND_BIT];
  assign irq_take = irq_i && ie_q;

  acc_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .ind_i      (ind),
    .irq_take_i (irq_take),
    .state_o    (state)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .a_i     (acc_q),
    .b_i     (mbr_q),
    .sum_o   (sum),
    .carry_o (c_add),
    .ovf_o   (v_add),
    .sign_o  (s_add),
    .zero_o  (z_add)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      ie_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH_A: mar_q <= pc_q;
        ST_FETCH_R: pc_q  <= pc_q + 1'b1;
        ST_FETCH_C, ST_IND_C, ST_EXEC_C: mbr_q <= mem_rdata_i;
        ST_DECODE: begin
          ir_q  <= mbr_q;
          mar_q <= mbr_q[ADDR_W-1:0];
          if (op == OP_ION) ie_q <= 1'b1;
        end
        ST_IND_M: mar_q <= mbr_q[ADDR_W-1:0];
        ST_EXEC_ALU: begin
          if (op == OP_LDA) acc_q <= mbr_q;
          else if (op == OP_ADD) begin
            acc_q   <= sum;
            flags_q <= {v_add, c_add, s_add, z_add};
          end
        end
        ST_STORE_M: mbr_q <= acc_q;
        ST_INT_M: begin
          mbr_q <= {{PAD_W{1'b0}}, pc_q};
          mar_q <= SAVE_ADDR[ADDR_W-1:0];
        end
        ST_INT_W: begin
          pc_q <= HANDLER_ADDR[ADDR_W-1:0];
          ie_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign mem_rd_o    = (state == ST_FETCH_R) || (state == ST_IND_R) || (state == ST_EXEC_R);
  assign mem_wr_o    = (state == ST_STORE_W) || (state == ST_INT_W);
  assign acc_o       = acc_q;
  assign pc_o        = pc_q;
  assign status_o    = {ie_q, flags_q};
endmodule

// File: rtl/acc_cpu_seq_checker.sv
module acc_cpu_seq_checker
  import acc_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 16,
  parameter logic [11:0] HANDLER_ADDR = 12'h100,
  parameter logic [11:0] SAVE_ADDR    = 12'h0FF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [STAT_W-1:0] status_o,
  input seq_state_e        state
);
  assert_one_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_read_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH_R) |-> (mem_rd_o && mem_addr_o == pc_o));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH_R) |=> (pc_o == $past(pc_o) + 1'b1));

  assert_flags_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_EXEC_ALU) |=> $stable(status_o[3:0]));

  assert_store_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_STORE_W) |-> (mem_wr_o && mem_wdata_o == acc_o));

  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_INT_M) |-> $past(status_o[STAT_IE]));

  assert_save_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_INT_W) |-> (mem_wr_o && mem_addr_o == SAVE_ADDR[ADDR_W-1:0]));

  assert_handler_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_INT_W) |=> (pc_o == HANDLER_ADDR[ADDR_W-1:0] && !status_o[STAT_IE]));
endmodule

bind acc_cpu_seq acc_cpu_seq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .HANDLER_ADDR(HANDLER_ADDR), .SAVE_ADDR(SAVE_ADDR)
) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .acc_o       (acc_o),
  .pc_o        (pc_o),
  .status_o    (status_o),
  .state       (state)
);

// File: tb/acc_cpu_seq_test.sv
module acc_cpu_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata = '0;
  logic        rd, wr;
  logic [15:0] acc;
  logic [11:0] pc;
  logic [4:0]  status;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [11:0] addr;
    logic [15:0] data;
    logic [4:0]  stat;
    logic [11:0] pc;
    string       req;
  } wr_item_t;
  wr_item_t exp_q[$];

  logic [15:0] mem [4096];

  always #5 clk = ~clk;

  acc_cpu_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .mem_rd_o(rd), .mem_wr_o(wr),
    .acc_o(acc), .pc_o(pc), .status_o(status)
  );

  always @(posedge clk) begin
    if (rd) rdata <= mem[addr];
    if (wr) mem[addr] <= wdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [11:0] a, input logic [15:0] d,
                           input logic [4:0] s, input logic [11:0] p, input string req);
    wr_item_t it;
    it.addr = a; it.data = d; it.stat = s; it.pc = p; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic wait_wr(input logic [11:0] a);
    do @(negedge clk); while (!(wr && addr == a));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && wr) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected write addr", {4'h0, addr}, 16'hxxxx);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(addr == it.addr, it.req, "write addr", {4'h0, addr}, {4'h0, it.addr});
        check(wdata == it.data, it.req, "write data", wdata, it.data);
        check(status == it.stat, it.req, "status", {11'h0, status}, {11'h0, it.stat});
        check(pc == it.pc, it.req, "pc", {4'h0, pc}, {4'h0, it.pc});
      end
    end
  end

  initial begin
    fork
      begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'hE000;  // opcode 7
        mem[12'h000] = 16'h0040;  // load 040
        mem[12'h001] = 16'h2041;  // add 041
        mem[12'h002] = 16'h4050;  // store 050
        mem[12'h003] = 16'h1042;  // load indirect 042
        mem[12'h004] = 16'h5044;  // store indirect 044
        mem[12'h005] = 16'hE000;  // unused opcode
        mem[12'h006] = 16'h0045;
        mem[12'h007] = 16'h2045;
        mem[12'h008] = 16'h2046;
        mem[12'h009] = 16'h4052;
        mem[12'h00A] = 16'h8000;  // enable interrupts
        mem[12'h00B] = 16'h0047;
        mem[12'h00C] = 16'h4053;
        mem[12'h100] = 16'h4054;  // handler
        mem[12'h040] = 16'h7FFF;
        mem[12'h041] = 16'h0001;
        mem[12'h042] = 16'h0043;
        mem[12'h043] = 16'h1234;
        mem[12'h044] = 16'hF051;  // upper bits ignored
        mem[12'h045] = 16'hFFFF;
        mem[12'h046] = 16'h0002;
        mem[12'h047] = 16'h00AA;

        // R4 overflow/sign; R5 store; R3 load
        expect_wr(12'h050, 16'h8000, 5'h0A, 12'h003, "R4");
        // R6 indirect load and store
        expect_wr(12'h051, 16'h1234, 5'h0A, 12'h005, "R6");
        // R4 carry and zero, R10 no-op skipped, R8 irq masked
        expect_wr(12'h052, 16'h0000, 5'h05, 12'h00A, "R8");
        // R5 store in the cycle the interrupt is accepted
        expect_wr(12'h053, 16'h00AA, 5'h15, 12'h00D, "R5");
        // R9 save of return address
        expect_wr(12'h0FF, 16'h000D, 5'h15, 12'h00D, "R9");
        // R9 handler runs with ie cleared
        expect_wr(12'h054, 16'h00AA, 5'h05, 12'h101, "R9");

        repeat (3) @(negedge clk);
        check(pc == 12'h0, "R1", "reset pc", {4'h0, pc}, 16'h0);
        check(acc == 16'h0, "R1", "reset acc", acc, 16'h0);
        check(status == 5'h0, "R1", "reset status", {11'h0, status}, 16'h0);
        check(!rd, "R1", "reset rd", {15'h0, rd}, 16'h0);
        check(!wr, "R1", "reset wr", {15'h0, wr}, 16'h0);
        rst_n = 1'b1;
        irq = 1'b1;  // masked while ie=0
        wait_wr(12'h052);
        irq = 1'b0;
        wait_wr(12'h053);
        irq = 1'b1;  // sampled at end of this store
        wait_wr(12'h054);
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending writes", 16'(exp_q.size()), 16'h0);
        check(acc == 16'h00AA, "R10", "final acc", acc, 16'h00AA);
        check(status == 5'h05, "R9", "final status", {11'h0, status}, 16'h05);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 16'h0, 16'h1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule